// File: doc/BRIEF.md
# Cascaded Two-Half Counter with Coherent Capture

This block is a 32-bit free-running up-counter made of two 16-bit halves. The low half advances on every clock in which the count enable is high. The high half advances only in the cycle where the low half rolls over from all ones to zero. Four capture slots take snapshots of the counter: slot A and slot B for each half. Each slot has its own external capture pin. Every pin passes through a two-flop synchronizer and an edge detector, and a shared setting selects the active edge.

When each half follows its own pin, the two halves can snap on different cycles, so the pair may show a torn 32-bit value. In linked mode the low half's pins drive both halves at once. Pin A loads both A slots and pin B loads both B slots in the same clock. A capture always stores the counter value as it stands after that clock edge, so a carry that happens in the capture cycle is already included. Software therefore always reads a consistent 32-bit value. Each slot has a sticky flag that a per-slot clear pulse resets.

Top module: `casc_capture_timer`

## Requirements
- R1: While rst_n is low at a rising clock edge, both counter halves, all four capture slots and all four flags become zero.
- R2: With cnt_en high, the low half increments by one per clock and wraps from FFFFh to 0000h.
- R3: The high half increments by one exactly at the edge where the low half wraps, and it holds at every other edge.
- R4: With cnt_en low, both halves hold their values. A capture taken in that time stores the held value.
- R5: A change on a capture pin, made between edges k-1 and k, loads the slot at edge k+2. The slot receives the counter value that is visible right after edge k+2.
- R6: edge_sel selects the active edge: 0 is rising, 1 is falling, 2 is both, and 3 disables all captures. An inactive edge loads nothing.
- R7: With link_en low, cap_in[i] loads only slot i. Slot 0 is low A, slot 1 is low B, slot 2 is high A and slot 3 is high B.
- R8: With link_en high, cap_in[0] loads slots 0 and 2 in the same clock, and cap_in[1] loads slots 1 and 3 in the same clock. Edges on cap_in[2] and cap_in[3] load nothing.
- R9: A linked capture at the low-half wrap edge stores the high half after its carry. The result is low 0000h next to the incremented high half.
- R10: cap_flags[i] is set when slot i loads and stays set until clr_flags[i] is high at a clock edge. A load in the same edge as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count enable |
| cap_in | input | 4 | Asynchronous capture pins, one per slot |
| edge_sel | input | 2 | Active edge select |
| link_en | input | 1 | Linked-capture mode |
| clr_flags | input | 4 | Per-slot flag clear |
| cnt_lo | output | 16 | Low counter half |
| cnt_hi | output | 16 | High counter half |
| capt_lo_a | output | 16 | Slot 0 value |
| capt_lo_b | output | 16 | Slot 1 value |
| capt_hi_a | output | 16 | Slot 2 value |
| capt_hi_b | output | 16 | Slot 3 value |
| cap_flags | output | 4 | Per-slot capture flags |

## Verification
Several rules are checked by assertions on every clock. The low half steps by one or holds. The carry moves the high half. A linked capture leaves both slots equal to the live counter one cycle later. A sticky flag cannot drop without a clear. The bench scenarios cover what needs a known stimulus: the two-cycle synchronizer latency, the effect of each edge_sel code, the routing of pins to slots in each mode, the ignored high-half pins in linked mode, a capture taken while counting is stopped, and a linked capture that lands exactly on the wrap edge.

// File: rtl/casc_cap_pkg.sv
// Shared types for the cascaded capture timer.
package casc_cap_pkg;
    // Active-edge selection for the capture pins.
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_OFF  = 2'd3
    } edge_sel_e;

    localparam int NUM_SLOTS = 4;
endpackage

// File: rtl/cap_edge_sync.sv
// Brings one asynchronous capture pin into the clock domain through two
// flops, then flags the selected edge for one cycle.
// Assumes: the pin is low after reset, so no edge is reported unless it moves.
module cap_edge_sync
    import casc_cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_e sel,
    output logic      hit
);
    logic [2:0] shift_q;
    logic       rise, fall;

    // Synchronizer stages followed by one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[1:0], pin};
    end

    assign rise = shift_q[1] & ~shift_q[2];
    assign fall = ~shift_q[1] & shift_q[2];

    // Edge qualification by the selected mode.
    always_comb begin
        unique case (sel)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    // R5/R6: a single-edge mode cannot report in two consecutive cycles.
    a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_RISE && hit && $stable(sel)) |=> !hit);
endmodule

// File: rtl/half_counter.sv
// One half of the cascaded counter: adds one when stepped and reports the
// wrap carry and the value it will hold after the coming edge.
module half_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value,
    output logic [W-1:0] value_next,
    output logic         carry
);
    localparam logic [W-1:0] ALL_ONES = '1;

    // Next value and carry toward the neighbouring half.
    assign value_next = step ? value + 1'b1 : value;
    assign carry      = step && (value == ALL_ONES);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else        value <= value_next;
    end

    // R2/R3: each edge either steps by one or holds.
    a_r2_step_or_hold: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> value == $past(value) + 1'b1);
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(value));
endmodule

// File: rtl/cap_slot.sv
// One capture slot: stores a snapshot on load and keeps a sticky flag.
// Assumes: a load has priority over a clear in the same cycle.
module cap_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] src,
    input  logic         clr,
    output logic [W-1:0] value,
    output logic         flag
);
    // Snapshot register.
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= src;
    end

    // Sticky flag, set by load, dropped by clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (load)  flag <= 1'b1;
        else if (clr)   flag <= 1'b0;
    end

    // R10: flag holds without a clear; it is set after every load.
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    a_r10_flag_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> flag);
endmodule

// File: rtl/casc_capture_timer.sv
// Cascaded 32-bit counter (two halves) with four capture slots.
// Slots 0/1 snapshot the low half, slots 2/3 the high half. In linked
// mode pins 0/1 load both halves in the same cycle with the post-edge value.
module casc_capture_timer
    import casc_cap_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [3:0]        cap_in,
    input  logic [1:0]        edge_sel,
    input  logic              link_en,
    input  logic [3:0]        clr_flags,
    output logic [HALF_W-1:0] cnt_lo,
    output logic [HALF_W-1:0] cnt_hi,
    output logic [HALF_W-1:0] capt_lo_a,
    output logic [HALF_W-1:0] capt_lo_b,
    output logic [HALF_W-1:0] capt_hi_a,
    output logic [HALF_W-1:0] capt_hi_b,
    output logic [3:0]        cap_flags
);
    localparam int HALF_SLOTS = NUM_SLOTS / 2;

    edge_sel_e         sel;
    logic [HALF_W-1:0] lo_next, hi_next;
    logic              lo_carry, hi_carry_unused;
    logic [3:0]        hit, slot_load;
    logic [HALF_W-1:0] slot_val [NUM_SLOTS];

    assign sel = edge_sel_e'(edge_sel);

    half_counter #(.W(HALF_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .step(cnt_en),
        .value(cnt_lo), .value_next(lo_next), .carry(lo_carry)
    );

    half_counter #(.W(HALF_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .step(lo_carry),
        .value(cnt_hi), .value_next(hi_next), .carry(hi_carry_unused)
    );

    // Per-pin synchronizers and per-slot capture registers.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        cap_edge_sync u_sync (
            .clk(clk), .rst_n(rst_n), .pin(cap_in[i]), .sel(sel), .hit(hit[i])
        );

        if (i < HALF_SLOTS) begin : g_low
            assign slot_load[i] = hit[i];
            cap_slot #(.W(HALF_W)) u_slot (
                .clk(clk), .rst_n(rst_n), .load(slot_load[i]), .src(lo_next),
                .clr(clr_flags[i]), .value(slot_val[i]), .flag(cap_flags[i])
            );
        end else begin : g_high
            // Linked mode borrows the low half's pin for the same letter.
            assign slot_load[i] = link_en ? hit[i-HALF_SLOTS] : hit[i];
            cap_slot #(.W(HALF_W)) u_slot (
                .clk(clk), .rst_n(rst_n), .load(slot_load[i]), .src(hi_next),
                .clr(clr_flags[i]), .value(slot_val[i]), .flag(cap_flags[i])
            );
        end
    end

    assign capt_lo_a = slot_val[0];
    assign capt_lo_b = slot_val[1];
    assign capt_hi_a = slot_val[2];
    assign capt_hi_b = slot_val[3];

    // R8: linked pair equals the live counter just after the capture edge.
    a_r8_linked_pair_a: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && hit[0]) |=> (capt_lo_a == cnt_lo && capt_hi_a == cnt_hi));
    a_r8_linked_pair_b: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && hit[1]) |=> (capt_lo_b == cnt_lo && capt_hi_b == cnt_hi));
    // R3: a wrap of the low half always moves the high half.
    a_r3_carry_steps_high: assert property (@(posedge clk) disable iff (!rst_n)
        lo_carry |=> (cnt_lo == '0 && cnt_hi == $past(cnt_hi) + 1'b1));
    // R9: a linked capture on the wrap edge stores a zero low half.
    a_r9_wrap_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && hit[0] && lo_carry) |=> capt_lo_a == '0);
endmodule

// File: tb/tb_casc_capture_timer.sv
module tb_casc_capture_timer;
    localparam int CLK_NS = 10;

    typedef struct packed {
        logic [1:0]  idx;
        logic [15:0] val;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [3:0]  cap_in = 4'h0;
    logic [1:0]  edge_sel = 2'd0;
    logic        link_en = 1'b0;
    logic [3:0]  clr_flags = 4'h0;
    logic [15:0] cnt_lo, cnt_hi, capt_lo_a, capt_lo_b, capt_hi_a, capt_hi_b;
    logic [3:0]  cap_flags;

    logic [31:0] model = '0;
    item_t       expq[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    casc_capture_timer dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_in(cap_in),
        .edge_sel(edge_sel), .link_en(link_en), .clr_flags(clr_flags),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .capt_lo_a(capt_lo_a),
        .capt_lo_b(capt_lo_b), .capt_hi_a(capt_hi_a), .capt_hi_b(capt_hi_b),
        .cap_flags(cap_flags)
    );

    // Reference counter from R1..R4.
    always @(posedge clk) begin
        if (!rst_n)      model <= '0;
        else if (cnt_en) model <= model + 1;
    end

    function automatic logic [15:0] slot_value(input logic [1:0] i);
        case (i)
            2'd0:    return capt_lo_a;
            2'd1:    return capt_lo_b;
            2'd2:    return capt_hi_a;
            default: return capt_hi_b;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected snapshots as the flags report them.
    always @(negedge clk) begin
        while (expq.size() > 0 && cap_flags[expq[0].idx]) begin
            item_t it;
            it = expq.pop_front();
            chk(slot_value(it.idx) == it.val, "R5", "capture value",
                {16'h0, slot_value(it.idx)}, {16'h0, it.val});
        end
    end

    // Driver: move one pin, clear the flags, predict the slots that load.
    task automatic stim(input int pin, input bit lvl, input logic [3:0] mask,
                        input string req);
        @(negedge clk);
        cap_in[pin] = lvl;
        clr_flags   = 4'hF;
        @(negedge clk);
        clr_flags   = 4'h0;
        @(posedge clk);
        @(posedge clk);
        #1;
        for (int j = 0; j < 4; j++)
            if (mask[j]) expq.push_back({2'(j), (j < 2) ? model[15:0] : model[31:16]});
        repeat (3) @(negedge clk);
        chk(cap_flags == mask, req, "flags after pin change",
            {28'h0, cap_flags}, {28'h0, mask});
        if (expq.size() != 0) begin
            chk(1'b0, req, "pending snapshots", expq.size(), 0);
            expq.delete();
        end
    endtask

    initial begin
        #(CLK_NS * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({cnt_hi, cnt_lo} == 0, "R1", "counter", {cnt_hi, cnt_lo}, 0);
        chk({capt_lo_a, capt_lo_b, capt_hi_a, capt_hi_b} == 0 && cap_flags == 0,
            "R1", "slots and flags", {28'h0, cap_flags}, 0);

        cnt_en = 1'b1;
        repeat (10) @(negedge clk);
        chk({cnt_hi, cnt_lo} == model, "R2", "counting", {cnt_hi, cnt_lo}, model);

        // R7: each pin reaches only its own slot (rising edges)
        edge_sel = 2'd0;
        stim(0, 1'b1, 4'b0001, "R7");
        stim(1, 1'b1, 4'b0010, "R7");
        stim(2, 1'b1, 4'b0100, "R7");
        stim(3, 1'b1, 4'b1000, "R7");
        // R6: falling edge ignored in rising mode
        stim(0, 1'b0, 4'b0000, "R6");
        edge_sel = 2'd1;
        stim(0, 1'b1, 4'b0000, "R6");
        stim(0, 1'b0, 4'b0001, "R6");
        edge_sel = 2'd2;
        stim(1, 1'b0, 4'b0010, "R6");
        stim(1, 1'b1, 4'b0010, "R6");
        edge_sel = 2'd3;
        stim(2, 1'b0, 4'b0000, "R6");
        edge_sel = 2'd2;

        // R4: stopped counter holds, capture stores held value
        @(negedge clk);
        cnt_en = 1'b0;
        @(negedge clk);
        held = cnt_lo;
        repeat (5) @(negedge clk);
        chk(cnt_lo == held, "R4", "low half held", {16'h0, cnt_lo}, {16'h0, held});
        stim(0, 1'b1, 4'b0001, "R4");
        chk(capt_lo_a == held, "R4", "held snapshot", {16'h0, capt_lo_a}, {16'h0, held});
        cnt_en = 1'b1;

        // R10: flag stays set until cleared
        repeat (5) @(negedge clk);
        chk(cap_flags[0] == 1'b1, "R10", "flag sticky", {31'h0, cap_flags[0]}, 1);
        clr_flags = 4'b0001;
        @(negedge clk);
        clr_flags = 4'b0000;
        chk(cap_flags[0] == 1'b0, "R10", "flag cleared", {31'h0, cap_flags[0]}, 0);

        // R8: linked mode
        link_en = 1'b1;
        stim(0, 1'b0, 4'b0101, "R8");
        stim(2, 1'b1, 4'b0000, "R8");
        stim(3, 1'b0, 4'b0000, "R8");
        stim(1, 1'b0, 4'b1010, "R8");

        // R3/R9: linked capture on the wrap edge
        do @(negedge clk); while (model[15:0] != 16'hFFFC);
        chk(cnt_hi == 16'h0, "R3", "high before wrap", {16'h0, cnt_hi}, 0);
        stim(0, 1'b1, 4'b0101, "R9");
        chk(capt_lo_a == 16'h0000 && capt_hi_a == 16'h0001, "R9", "wrap snapshot",
            {capt_hi_a, capt_lo_a}, 32'h0001_0000);
        chk(cnt_hi == 16'h1, "R3", "high after wrap", {16'h0, cnt_hi}, 1);
        chk({cnt_hi, cnt_lo} == model, "R2", "wrap value", {cnt_hi, cnt_lo}, model);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule